// File: doc/BRIEF.md
# Multi-Bank Chip-Select Address Matcher

This block decides which external memory device an internal bus access belongs to. It holds four programmable bank descriptors. Each descriptor has a base address, a compare mask, a valid flag, a port width, a read-only flag, a wait-state count and a burst-inhibit flag. It also holds one remapping window that takes precedence over every bank. When an access starts, the block compares the 17-bit access address against all descriptors in parallel. It drives one active-high chip select straight from that comparison, in the same cycle, and captures the winning bank's attributes into registers for the external cycle logic.

Writes that land in a read-only bank are refused: no chip select is driven and a sticky per-bank flag records the event until software clears it. All descriptors are programmed through a small register write port. Bus cycle timing and byte-lane steering live elsewhere.

Top module: `bank_select_unit`

## Requirements
- R1: A bank matches an address when, for every bit i of the 17 address bits whose mask bit i is 1, address bit i equals base bit i; bits with mask 0 are not compared.
- R2: A bank whose valid flag is 0 never matches.
- R3: When several banks match, only the lowest-indexed one drives its chip select (`cs` bit n for bank n) and supplies the attributes.
- R4: An address inside the enabled remapping window raises `dmap_sel`, drives no bank chip select, and never counts as a write-protect violation, even where a bank also matches.
- R5: A write access (`acc_write`=1) whose winning bank is read-only drives no chip select, and sets `wp_status` bit n for that bank n one cycle later; the bit stays set.
- R6: When neither a bank nor the window matches an access, `cs` is all zero and `no_match` is 1 in the same cycle.
- R7: In the cycle after an access start, `att_hit`, `att_bank`, `att_port_size`, `att_wait` and `att_burst_inh` show the selected bank's index and fields (port size code 00 = 32 bit, 01 = 8 bit, 10 = 16 bit). When no bank chip select was driven, `att_hit` is 0 and the other attribute outputs are 0.
- R8: A write to the status clear register (`cfg_addr` 10) clears each `wp_status` bit whose `cfg_data` bit is 1 and leaves the others unchanged.
- R9: While `acc_start` is 0, `cs`, `dmap_sel` and `no_match` are 0 and the attribute outputs hold their values.
- R10: After reset, every descriptor is invalid, the window is disabled, `wp_status` is 0, `att_hit` is 0, and any access reports `no_match`.
- R11: Register map: `cfg_addr` n (0..3) is bank n base word {port_size[19:18], valid[17], base[16:0]}; `cfg_addr` 4+n is bank n option word {burst_inh[22], wait[21:18], read_only[17], mask[16:0]}; 8 is the window base word {enable[17], base[16:0]}; 9 is the window mask word {mask[16:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select |
| cfg_data | input | 23 | Register write data |
| acc_start | input | 1 | Access start strobe |
| acc_addr | input | 17 | Access address |
| acc_write | input | 1 | Access is a write |
| cs | output | 4 | Bank chip selects, active high, combinational |
| dmap_sel | output | 1 | Remapping window selected |
| no_match | output | 1 | Access matched nothing |
| att_hit | output | 1 | Registered: a bank was selected |
| att_bank | output | 2 | Registered selected bank index |
| att_port_size | output | 2 | Registered port size code |
| att_wait | output | 4 | Registered wait-state count |
| att_burst_inh | output | 1 | Registered burst-inhibit flag |
| wp_status | output | 4 | Sticky write-protect violation flags |

## Verification
The bench sweeps the whole 17-bit address space twice against a layout built to expose the corner cases. In that layout bank 1 nests inside bank 0, the remapping window overlaps a read-only bank, and one bank starts out invalid. A priority encoder that picks the highest index would hand the nested region to bank 1 and refuse writes there. An override checked after the banks would let window addresses drive a chip select or flag violations. A mask applied the wrong way round would shift every region boundary. Directed accesses then check that refused writes set only their own status bit, that a partial clear spares the other bits, and that attributes hold while no access is started.

// File: rtl/bank_select_pkg.sv
package bank_select_pkg;
  typedef enum logic [1:0] {
    PSZ_32 = 2'b00,
    PSZ_8  = 2'b01,
    PSZ_16 = 2'b10,
    PSZ_RSV = 2'b11
  } port_size_e;

  function automatic int unsigned opt_offset(input int unsigned nb);
    return nb;
  endfunction

  function automatic int unsigned win_base_offset(input int unsigned nb);
    return 2 * nb;
  endfunction

  function automatic int unsigned win_mask_offset(input int unsigned nb);
    return 2 * nb + 1;
  endfunction

  function automatic int unsigned stat_clr_offset(input int unsigned nb);
    return 2 * nb + 2;
  endfunction
endpackage

// File: rtl/bank_cfg_regs.sv
module bank_cfg_regs #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 17,
  parameter int WAIT_W    = 4,
  parameter int CFG_AW    = 4,
  localparam int CFG_W    = ADDR_W + WAIT_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [CFG_W-1:0]     cfg_data,
  input  logic [NUM_BANKS-1:0] viol_set,
  output logic [ADDR_W-1:0]    base_q  [NUM_BANKS],
  output logic [ADDR_W-1:0]    mask_q  [NUM_BANKS],
  output logic [NUM_BANKS-1:0] valid_q,
  output logic [NUM_BANKS-1:0] ro_q,
  output logic [NUM_BANKS-1:0] bi_q,
  output logic [1:0]           ps_q    [NUM_BANKS],
  output logic [WAIT_W-1:0]    wait_q  [NUM_BANKS],
  output logic [ADDR_W-1:0]    wbase_q,
  output logic [ADDR_W-1:0]    wmask_q,
  output logic                 wen_q,
  output logic [NUM_BANKS-1:0] status_q
);
  import bank_select_pkg::*;

  localparam int unsigned OPT_OFS  = opt_offset(NUM_BANKS);
  localparam int unsigned WB_OFS   = win_base_offset(NUM_BANKS);
  localparam int unsigned WM_OFS   = win_mask_offset(NUM_BANKS);
  localparam int unsigned CLR_OFS  = stat_clr_offset(NUM_BANKS);
  localparam int BIT_RO   = ADDR_W;
  localparam int BIT_WLO  = ADDR_W + 1;
  localparam int BIT_BI   = ADDR_W + WAIT_W + 1;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wr_base, wr_opt;
    assign wr_base = cfg_we && (cfg_addr == CFG_AW'(b));
    assign wr_opt  = cfg_we && (cfg_addr == CFG_AW'(OPT_OFS + b));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[b]  <= '0;
        valid_q[b] <= 1'b0;
        ps_q[b]    <= PSZ_32;
      end else if (wr_base) begin
        base_q[b]  <= cfg_data[ADDR_W-1:0];
        valid_q[b] <= cfg_data[ADDR_W];
        ps_q[b]    <= cfg_data[ADDR_W+2:ADDR_W+1];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[b] <= '0;
        ro_q[b]   <= 1'b0;
        wait_q[b] <= '0;
        bi_q[b]   <= 1'b0;
      end else if (wr_opt) begin
        mask_q[b] <= cfg_data[ADDR_W-1:0];
        ro_q[b]   <= cfg_data[BIT_RO];
        wait_q[b] <= cfg_data[BIT_BI-1:BIT_WLO];
        bi_q[b]   <= cfg_data[BIT_BI];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbase_q <= '0;
      wen_q   <= 1'b0;
      wmask_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_AW'(WB_OFS)) begin
        wbase_q <= cfg_data[ADDR_W-1:0];
        wen_q   <= cfg_data[ADDR_W];
      end
      if (cfg_addr == CFG_AW'(WM_OFS)) begin
        wmask_q <= cfg_data[ADDR_W-1:0];
      end
    end
  end

  logic [NUM_BANKS-1:0] clr_vec;
  assign clr_vec = (cfg_we && cfg_addr == CFG_AW'(CLR_OFS)) ? cfg_data[NUM_BANKS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q & ~clr_vec) | viol_set;
  end
endmodule

// File: rtl/bank_addr_cmp.sv
module bank_addr_cmp #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 17
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [ADDR_W-1:0]    base_q [NUM_BANKS],
  input  logic [ADDR_W-1:0]    mask_q [NUM_BANKS],
  input  logic [NUM_BANKS-1:0] valid_q,
  input  logic [ADDR_W-1:0]    wbase_q,
  input  logic [ADDR_W-1:0]    wmask_q,
  input  logic                 wen_q,
  output logic [NUM_BANKS-1:0] bank_hit,
  output logic                 win_hit
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
    assign bank_hit[b] = valid_q[b] && (((addr ^ base_q[b]) & mask_q[b]) == '0);
  end
  assign win_hit = wen_q && (((addr ^ wbase_q) & wmask_q) == '0);
endmodule

// File: rtl/bank_prio_pick.sv
module bank_prio_pick #(
  parameter int NUM_BANKS = 4,
  localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [NUM_BANKS-1:0] req,
  output logic [NUM_BANKS-1:0] grant,
  output logic [IDX_W-1:0]     idx,
  output logic                 any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (req[b]) begin
        grant = '0;
        grant[b] = 1'b1;
        idx = IDX_W'(b);
      end
    end
  end
  assign any = |req;
endmodule

// File: rtl/bank_select_unit.sv
module bank_select_unit #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 17,
  parameter int WAIT_W    = 4,
  parameter int CFG_AW    = 4,
  localparam int CFG_W    = ADDR_W + WAIT_W + 2,
  localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [CFG_W-1:0]     cfg_data,
  input  logic                 acc_start,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic                 acc_write,
  output logic [NUM_BANKS-1:0] cs,
  output logic                 dmap_sel,
  output logic                 no_match,
  output logic                 att_hit,
  output logic [IDX_W-1:0]     att_bank,
  output logic [1:0]           att_port_size,
  output logic [WAIT_W-1:0]    att_wait,
  output logic                 att_burst_inh,
  output logic [NUM_BANKS-1:0] wp_status
);
  logic [ADDR_W-1:0]    base_q [NUM_BANKS];
  logic [ADDR_W-1:0]    mask_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] valid_q, ro_q, bi_q;
  logic [1:0]           ps_q   [NUM_BANKS];
  logic [WAIT_W-1:0]    wait_q [NUM_BANKS];
  logic [ADDR_W-1:0]    wbase_q, wmask_q;
  logic                 wen_q;
  logic [NUM_BANKS-1:0] viol_set;

  bank_cfg_regs #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .CFG_AW(CFG_AW)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .viol_set(viol_set), .base_q(base_q), .mask_q(mask_q), .valid_q(valid_q),
    .ro_q(ro_q), .bi_q(bi_q), .ps_q(ps_q), .wait_q(wait_q), .wbase_q(wbase_q),
    .wmask_q(wmask_q), .wen_q(wen_q), .status_q(wp_status)
  );

  logic [NUM_BANKS-1:0] bank_hit;
  logic                 win_hit;

  bank_addr_cmp #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_cmp (
    .addr(acc_addr), .base_q(base_q), .mask_q(mask_q), .valid_q(valid_q),
    .wbase_q(wbase_q), .wmask_q(wmask_q), .wen_q(wen_q),
    .bank_hit(bank_hit), .win_hit(win_hit)
  );

  logic [NUM_BANKS-1:0] grant;
  logic [IDX_W-1:0]     win_idx;
  logic                 any_bank;

  bank_prio_pick #(.NUM_BANKS(NUM_BANKS)) u_pick (
    .req(bank_hit), .grant(grant), .idx(win_idx), .any(any_bank)
  );

  logic bank_taken, refused, granted;
  assign bank_taken = acc_start && any_bank && !win_hit;
  assign refused    = bank_taken && acc_write && ro_q[win_idx];
  assign granted    = bank_taken && !refused;

  assign cs       = granted ? grant : '0;
  assign dmap_sel = acc_start && win_hit;
  assign no_match = acc_start && !win_hit && !any_bank;
  assign viol_set = refused ? grant : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      att_hit       <= 1'b0;
      att_bank      <= '0;
      att_port_size <= '0;
      att_wait      <= '0;
      att_burst_inh <= 1'b0;
    end else if (acc_start) begin
      att_hit       <= granted;
      att_bank      <= granted ? win_idx : '0;
      att_port_size <= granted ? ps_q[win_idx] : '0;
      att_wait      <= granted ? wait_q[win_idx] : '0;
      att_burst_inh <= granted && bi_q[win_idx];
    end
  end
endmodule

// File: rtl/bank_select_chk.sv
module bank_select_chk #(
  parameter int NUM_BANKS = 4,
  parameter int WAIT_W    = 4,
  parameter int CFG_AW    = 4,
  parameter int IDX_W     = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_we,
  input logic [CFG_AW-1:0]    cfg_addr,
  input logic                 acc_start,
  input logic                 acc_write,
  input logic [NUM_BANKS-1:0] cs,
  input logic                 dmap_sel,
  input logic                 no_match,
  input logic                 att_hit,
  input logic [IDX_W-1:0]     att_bank,
  input logic [1:0]           att_port_size,
  input logic [WAIT_W-1:0]    att_wait,
  input logic                 att_burst_inh,
  input logic [NUM_BANKS-1:0] wp_status
);
  localparam int unsigned CLR_OFS = 2 * NUM_BANKS + 2;
  logic clr_wr;
  assign clr_wr = cfg_we && (cfg_addr == CFG_AW'(CLR_OFS));

  assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (rst) $onehot0(cs));

  assert_window_no_cs_R4: assert property (@(posedge clk) disable iff (rst)
    dmap_sel |-> (cs == '0 && !no_match));

  assert_nomatch_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    no_match |-> (cs == '0 && !dmap_sel));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !acc_start |-> (cs == '0 && !dmap_sel && !no_match));

  assert_attr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !acc_start |=> ($stable(att_hit) && $stable(att_bank) && $stable(att_port_size)
                    && $stable(att_wait) && $stable(att_burst_inh)));

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> (($past(wp_status) & ~wp_status) == '0));

  assert_status_needs_write_R5: assert property (@(posedge clk) disable iff (rst)
    !(acc_start && acc_write) |=> ((wp_status & ~$past(wp_status)) == '0));

  assert_refused_no_cs_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_start && acc_write && cs != '0) |=> ((wp_status & ~$past(wp_status)) == '0));
endmodule

bind bank_select_unit bank_select_chk #(
  .NUM_BANKS(NUM_BANKS), .WAIT_W(WAIT_W), .CFG_AW(CFG_AW), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .acc_start(acc_start),
  .acc_write(acc_write), .cs(cs), .dmap_sel(dmap_sel), .no_match(no_match),
  .att_hit(att_hit), .att_bank(att_bank), .att_port_size(att_port_size),
  .att_wait(att_wait), .att_burst_inh(att_burst_inh), .wp_status(wp_status)
);

// File: tb/tb_bank_select_unit.sv
module tb_bank_select_unit;
  localparam int NB = 4;
  localparam int AW = 17;
  localparam int WW = 4;
  localparam int CW = AW + WW + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [CW-1:0] cfg_data = '0;
  logic acc_start = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic acc_write = 1'b0;
  logic [NB-1:0] cs;
  logic dmap_sel, no_match, att_hit, att_burst_inh;
  logic [1:0] att_bank, att_port_size;
  logic [WW-1:0] att_wait;
  logic [NB-1:0] wp_status;

  bank_select_unit dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .acc_start(acc_start), .acc_addr(acc_addr), .acc_write(acc_write), .cs(cs),
    .dmap_sel(dmap_sel), .no_match(no_match), .att_hit(att_hit), .att_bank(att_bank),
    .att_port_size(att_port_size), .att_wait(att_wait), .att_burst_inh(att_burst_inh),
    .wp_status(wp_status)
  );

  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, cycles=%0d expected < 150000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // bench-side model of the programmed descriptors
  logic [AW-1:0] m_base [NB];
  logic [AW-1:0] m_mask [NB];
  logic [NB-1:0] m_valid, m_ro, m_bi;
  logic [1:0]    m_ps [NB];
  logic [WW-1:0] m_wait [NB];
  logic [AW-1:0] m_wbase, m_wmask;
  logic          m_wen;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_bank(input int b, input logic [AW-1:0] base, input logic [AW-1:0] mask,
                          input logic v, input logic [1:0] ps, input logic ro,
                          input logic [WW-1:0] w, input logic bi);
    m_base[b] = base; m_mask[b] = mask; m_valid[b] = v; m_ps[b] = ps;
    m_ro[b] = ro; m_wait[b] = w; m_bi[b] = bi;
    cfg_write(4'(b), CW'({ps, v, base}));          // R11 base word
    cfg_write(4'(4 + b), {bi, w, ro, mask});       // R11 option word
  endtask

  // -2 window, -1 nothing, else bank index
  function automatic int exp_sel(input logic [AW-1:0] a);
    if (m_wen && (((a ^ m_wbase) & m_wmask) == 0)) return -2;
    for (int b = 0; b < NB; b++)
      if (m_valid[b] && (((a ^ m_base[b]) & m_mask[b]) == 0)) return b;
    return -1;
  endfunction

  function automatic logic [NB-1:0] exp_cs(input logic [AW-1:0] a, input logic wr);
    int s = exp_sel(a);
    if (s < 0) return '0;
    if (wr && m_ro[s]) return '0;
    return NB'(1) << s;
  endfunction

  task automatic sweep(input string tag);
    @(negedge clk);
    acc_start = 1'b1; acc_write = 1'b0;
    for (int a = 0; a < (1 << AW); a++) begin
      acc_addr = AW'(a);
      #1;
      begin
        int s = exp_sel(AW'(a));
        check({tag, " R1 R2 R3 R4 R6 sweep"}, {cs, dmap_sel, no_match},
              {exp_cs(AW'(a), 1'b0), s == -2, s == -1});
      end
    end
    @(negedge clk);
    acc_start = 1'b0;
  endtask

  // one access; checks comb outputs, then registered attributes and status
  task automatic access(input string tag, input logic [AW-1:0] a, input logic wr,
                        input logic [NB-1:0] stat_exp);
    int s;
    logic [NB-1:0] c;
    @(negedge clk);
    acc_start = 1'b1; acc_addr = a; acc_write = wr;
    #1;
    s = exp_sel(a);
    c = exp_cs(a, wr);
    check({tag, " R5 R6 comb"}, {cs, dmap_sel, no_match}, {c, s == -2, s == -1});
    @(negedge clk);
    acc_start = 1'b0; acc_write = 1'b0;
    #1;
    if (c != 0)
      check({tag, " R7 attributes"}, {att_hit, att_bank, att_port_size, att_wait, att_burst_inh},
            {1'b1, 2'(s), m_ps[s], m_wait[s], m_bi[s]});
    else
      check({tag, " R7 no-hit attributes"},
            {att_hit, att_bank, att_port_size, att_wait, att_burst_inh}, '0);
    check({tag, " R5 status"}, 32'(wp_status), 32'(stat_exp));
  endtask

  initial begin
    m_valid = '0; m_ro = '0; m_bi = '0; m_wen = 1'b0; m_wbase = '0; m_wmask = '0;
    for (int b = 0; b < NB; b++) begin
      m_base[b] = '0; m_mask[b] = '0; m_ps[b] = '0; m_wait[b] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset state
    @(negedge clk);
    acc_start = 1'b1; acc_addr = 17'h00000;
    #1;
    check("R10 reset access", {cs, dmap_sel, no_match, att_hit, wp_status}, {4'b0, 1'b0, 1'b1, 1'b0, 4'b0});
    acc_addr = 17'h1FFFF;
    #1;
    check("R10 reset access top", {cs, no_match}, {4'b0, 1'b1});
    @(negedge clk);
    acc_start = 1'b0;

    // layout: bank1 nested in bank0, window overlaps read-only bank2, bank3 invalid
    set_bank(0, 17'h01000, 17'h1F000, 1'b1, 2'b01, 1'b0, 4'd3, 1'b0);
    set_bank(1, 17'h01800, 17'h1F800, 1'b1, 2'b10, 1'b1, 4'd5, 1'b1);
    set_bank(2, 17'h10000, 17'h10000, 1'b1, 2'b00, 1'b1, 4'd0, 1'b1);
    set_bank(3, 17'h08000, 17'h1C000, 1'b0, 2'b10, 1'b0, 4'd15, 1'b0);
    m_wbase = 17'h11000; m_wmask = 17'h1F000; m_wen = 1'b1;
    cfg_write(4'd8, CW'({1'b1, 17'h11000}));
    cfg_write(4'd9, CW'(17'h1F000));

    sweep("pass1");

    access("bank0 read", 17'h01234, 1'b0, 4'b0000);
    access("R3 nested write", 17'h01804, 1'b1, 4'b0000);
    access("R5 ro write bank2", 17'h10004, 1'b1, 4'b0100);
    access("bank2 read", 17'h10004, 1'b0, 4'b0100);
    access("R4 window write", 17'h11008, 1'b1, 4'b0100);
    access("R2 invalid bank3", 17'h0A000, 1'b0, 4'b0100);

    // R9: idle strobe, attributes hold, address in bank0
    @(negedge clk);
    acc_addr = 17'h01000; acc_write = 1'b1;
    #1;
    check("R9 idle comb", {cs, dmap_sel, no_match}, 6'b0);
    @(negedge clk);
    check("R9 attributes held", {att_hit, att_port_size, att_wait}, {1'b0, 2'b00, 4'd0});
    check("R9 status unchanged", 32'(wp_status), 32'h4);
    acc_write = 1'b0;

    // R2: enable bank3, re-sweep
    set_bank(3, 17'h08000, 17'h1C000, 1'b1, 2'b10, 1'b0, 4'd15, 1'b0);
    sweep("pass2");
    access("R2 bank3 valid", 17'h0A000, 1'b0, 4'b0100);
    access("R5 ro write bank2 again", 17'h1F000, 1'b1, 4'b0100);

    // R8: clear register at cfg_addr 10
    cfg_write(4'd10, CW'(4'b1011));
    #1;
    check("R8 clear other bits", 32'(wp_status), 32'h4);
    cfg_write(4'd10, CW'(4'b0100));
    #1;
    check("R8 clear set bit", 32'(wp_status), 32'h0);
    access("R5 after clear", 17'h10000, 1'b1, 4'b0100);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule